// File: doc/BRIEF.md
# Direct-Mapped Read-Only Byte Cache

This block puts a four-entry direct-mapped cache in front of a read-only memory that is one 32-bit word wide. A requester sends an 8-bit byte address with a one-cycle strobe while the block is idle. The block answers with one data byte and a one-cycle ready pulse. Each entry holds a four-byte line. When a lookup misses, the block reads the whole line in one access to the backing memory and stores it in the entry that the address selects.

A hit answers on the next cycle. A miss answers a fixed ten cycles after the request, which models a slow memory. The backing memory is read only on a miss. Two free-running counters record the accepted requests and the hits. The number of misses is the first count minus the second.

Top module: `ro_line_cache`

## Requirements
- R1: After reset, `rsp_ready` and `mem_rd_en` are low and both counters read zero. Every entry is invalid, so the first request to any line misses.
- R2: The address splits into three fields. Bits 1:0 are the byte offset, bits 3:2 are the entry index and bits 7:4 are the tag. A request hits only when the indexed entry is valid and its stored tag equals the address tag. Otherwise it misses.
- R3: A request that hits raises `rsp_ready` in the cycle after it is accepted and presents the cached byte. `mem_rd_en` stays low for the whole request.
- R4: A request that misses raises `mem_rd_en` for exactly one cycle, the cycle after it is accepted. During that cycle `mem_rd_addr` equals address bits 7:2. The line is taken from `mem_rd_data` in that same cycle.
- R5: For a miss, `rsp_ready` rises in the tenth cycle after the cycle in which the request was accepted. For both hits and misses, `rsp_ready` is a pulse that lasts one cycle.
- R6: Byte k of a line (k = byte offset) is bits 8k+7:8k of the memory word. Offset 0 maps to bits 7:0 and offset 3 maps to bits 31:24.
- R7: A fill writes only the indexed entry: all four bytes, the new tag and a set valid flag. Lines held by the other entries stay intact, while a request with another tag to the same index evicts the old line.
- R8: A `req_valid` strobe that arrives while a miss is in progress is ignored. It adds no count and produces no response.
- R9: `access_count` increments once per accepted request. `hit_count` increments once per accepted request that hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken while the block is idle |
| req_addr | input | 8 | Requested byte address |
| rsp_ready | output | 1 | One-cycle pulse: `rsp_data` is valid |
| rsp_data | output | 8 | Returned byte |
| mem_rd_en | output | 1 | Backing-memory read strobe |
| mem_rd_addr | output | 6 | Word address for the backing memory |
| mem_rd_data | input | 32 | Word from the backing memory, combinational to `mem_rd_addr` |
| access_count | output | 16 | Accepted requests |
| hit_count | output | 16 | Accepted requests that hit |

## Verification
Every byte address is swept upward and then downward, so each line is first filled and then hit at all four offsets. A wrong field split or a swapped byte lane shows up as a wrong returned byte or a hit and miss pattern that does not match the model. A targeted conflict sequence evicts one index and then checks that a neighbouring index still hits. A design that cleared or refilled the wrong entry would then answer after ten cycles instead of one. In another test a strobe is held high through a whole miss. A block that accepted it would bump `access_count` or issue a second ready pulse. Read-strobe timing and the exact ten-cycle latency are checked for every request, so an off-by-one wait counter or a memory read on a hit is caught at once.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2
    } rlc_state_e;

endpackage

// File: rtl/rlc_line_store.sv
module rlc_line_store #(
    parameter int TAG_W  = 4,
    parameter int IDX_W  = 2,
    parameter int OFF_W  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [IDX_W-1:0]              lk_idx,
    input  logic [TAG_W-1:0]              lk_tag,
    input  logic [OFF_W-1:0]              lk_off,
    output logic                          lk_hit,
    output logic [BYTE_W-1:0]             lk_byte,
    input  logic                          fill_en,
    input  logic [IDX_W-1:0]              fill_idx,
    input  logic [TAG_W-1:0]              fill_tag,
    input  logic [(BYTE_W<<OFF_W)-1:0]    fill_line
);

    localparam int ENTRIES = 1 << IDX_W;
    localparam int LINE_W  = BYTE_W << OFF_W;

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
        logic [ENTRIES-1:0][LINE_W-1:0] data;
    } store_t;

    store_t st_d, st_q;
    logic [ENTRIES-1:0] entry_match;
    logic [LINE_W-1:0]  sel_line;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        assign entry_match[e] = st_q.valid[e] && (st_q.tag[e] == lk_tag);
    end

    always_comb begin
        st_d     = st_q;
        lk_hit   = entry_match[lk_idx];
        sel_line = st_q.data[lk_idx];
        lk_byte  = sel_line[lk_off*BYTE_W +: BYTE_W];
        if (fill_en) begin
            st_d.valid[fill_idx] = 1'b1;
            st_d.tag[fill_idx]   = fill_tag;
            st_d.data[fill_idx]  = fill_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: a fill leaves its entry valid with the fill tag and data
    assert_fill_loads_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (st_q.valid[$past(fill_idx)]
                     && st_q.tag[$past(fill_idx)] == $past(fill_tag)
                     && st_q.data[$past(fill_idx)] == $past(fill_line)));

endmodule

// File: rtl/rlc_ctrl.sv
module rlc_ctrl
    import rlc_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int OFF_W    = 2,
    parameter int BYTE_W   = 8,
    parameter int MISS_LAT = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    output logic [ADDR_W-1:0]        lk_addr,
    input  logic                     lk_hit,
    input  logic [BYTE_W-1:0]        lk_byte,
    output logic                     fill_en,
    output logic                     mem_rd_en,
    output logic [ADDR_W-OFF_W-1:0]  mem_rd_addr,
    output logic                     rsp_ready,
    output logic [BYTE_W-1:0]        rsp_data,
    output logic                     acc_evt,
    output logic                     hit_evt
);

    localparam int CNT_W = $clog2(MISS_LAT + 1);

    typedef struct packed {
        rlc_state_e         state;
        logic [ADDR_W-1:0]  addr;
        logic [CNT_W-1:0]   cnt;
        logic               ready;
        logic [BYTE_W-1:0]  data;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.ready = 1'b0;
        acc_evt   = 1'b0;
        hit_evt   = 1'b0;
        lk_addr   = (c_q.state == ST_IDLE) ? req_addr : c_q.addr;
        case (c_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    acc_evt  = 1'b1;
                    c_d.addr = req_addr;
                    if (lk_hit) begin
                        hit_evt   = 1'b1;
                        c_d.ready = 1'b1;
                        c_d.data  = lk_byte;
                    end else begin
                        c_d.state = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                c_d.cnt   = CNT_W'(MISS_LAT - 2);
                c_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (c_q.cnt == CNT_W'(1)) begin
                    c_d.ready = 1'b1;
                    c_d.data  = lk_byte;
                    c_d.state = ST_IDLE;
                end else begin
                    c_d.cnt = c_q.cnt - CNT_W'(1);
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{state: ST_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign fill_en     = (c_q.state == ST_FETCH);
    assign mem_rd_en   = (c_q.state == ST_FETCH);
    assign mem_rd_addr = c_q.addr[ADDR_W-1:OFF_W];
    assign rsp_ready   = c_q.ready;
    assign rsp_data    = c_q.data;

    initial begin
        assert_latency_param_R5: assert (MISS_LAT >= 3);
    end

    // R4: an accepted miss starts a memory read in the following cycle
    assert_rd_after_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_IDLE && req_valid && !lk_hit) |=> mem_rd_en);

    // R4: the read strobe lasts one cycle
    assert_rd_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R3: a hit never touches the backing memory
    assert_no_rd_on_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_IDLE && req_valid && lk_hit) |=> (!mem_rd_en && rsp_ready));

    // R5: no response while the line is being fetched
    assert_no_ready_in_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !rsp_ready);

    // R8: strobes during a miss are not counted
    assert_busy_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state != ST_IDLE) |-> !acc_evt);

endmodule

// File: rtl/rlc_stats.sv
module rlc_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_evt,
    input  logic             hit_evt,
    output logic [CNT_W-1:0] access_count,
    output logic [CNT_W-1:0] hit_count
);

    typedef struct packed {
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] hit;
    } stats_t;

    stats_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (acc_evt)            s_d.acc = s_q.acc + CNT_W'(1);
        if (acc_evt && hit_evt) s_d.hit = s_q.hit + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign access_count = s_q.acc;
    assign hit_count    = s_q.hit;

    // R9: the hit count moves only together with the access count
    assert_hit_with_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hit_count) |-> !$stable(access_count));

endmodule

// File: rtl/ro_line_cache.sv
module ro_line_cache #(
    parameter int ADDR_W   = 8,
    parameter int IDX_W    = 2,
    parameter int OFF_W    = 2,
    parameter int BYTE_W   = 8,
    parameter int MISS_LAT = 10,
    parameter int CNT_W    = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic [ADDR_W-1:0]               req_addr,
    output logic                            rsp_ready,
    output logic [BYTE_W-1:0]               rsp_data,
    output logic                            mem_rd_en,
    output logic [ADDR_W-OFF_W-1:0]         mem_rd_addr,
    input  logic [(BYTE_W<<OFF_W)-1:0]      mem_rd_data,
    output logic [CNT_W-1:0]                access_count,
    output logic [CNT_W-1:0]                hit_count
);

    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [ADDR_W-1:0] lk_addr;
    logic              lk_hit;
    logic [BYTE_W-1:0] lk_byte;
    logic              fill_en;
    logic              acc_evt;
    logic              hit_evt;

    rlc_ctrl #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BYTE_W(BYTE_W), .MISS_LAT(MISS_LAT)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_byte(lk_byte),
        .fill_en(fill_en), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .acc_evt(acc_evt), .hit_evt(hit_evt)
    );

    rlc_line_store #(
        .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .BYTE_W(BYTE_W)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_addr[OFF_W +: IDX_W]),
        .lk_tag(lk_addr[ADDR_W-1 -: TAG_W]),
        .lk_off(lk_addr[OFF_W-1:0]),
        .lk_hit(lk_hit), .lk_byte(lk_byte),
        .fill_en(fill_en),
        .fill_idx(lk_addr[OFF_W +: IDX_W]),
        .fill_tag(lk_addr[ADDR_W-1 -: TAG_W]),
        .fill_line(mem_rd_data)
    );

    rlc_stats #(.CNT_W(CNT_W)) stats_i (
        .clk(clk), .rst_n(rst_n),
        .acc_evt(acc_evt), .hit_evt(hit_evt),
        .access_count(access_count), .hit_count(hit_count)
    );

endmodule

// File: tb/ro_line_cache_tb_top.sv
`timescale 1ns/1ps
module ro_line_cache_tb_top;

    localparam int LAT = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_addr = '0;
    logic        rsp_ready;
    logic [7:0]  rsp_data;
    logic        mem_rd_en;
    logic [5:0]  mem_rd_addr;
    logic [31:0] mem_rd_data;
    logic [15:0] access_count;
    logic [15:0] hit_count;

    int n_chk = 0;
    int n_err = 0;
    int exp_acc = 0;
    int exp_hit = 0;
    bit m_valid [4];
    logic [3:0] m_tag [4];

    always #5 clk = ~clk;

    ro_line_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data),
        .access_count(access_count), .hit_count(hit_count)
    );

    function automatic logic [7:0] mem_byte(input int a);
        return 8'((a * 37 + 91) & 255);
    endfunction

    // R6: byte k of a word sits at bits 8k+7:8k
    always_comb begin
        for (int k = 0; k < 4; k++)
            mem_rd_data[k*8 +: 8] = mem_byte(int'(mem_rd_addr) * 4 + k);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic [7:0] a, input bit hold_busy, input string lat_req);
        int idx = int'(a[3:2]);
        bit hit = m_valid[idx] && (m_tag[idx] == a[7:4]);
        int k = 1;
        int got_lat = 0;
        int rd_cnt = 0;
        int rd_k = 0;
        int rd_a = 0;
        int got_data = 0;
        int acc0;
        @(negedge clk);
        acc0 = int'(access_count);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        while (k <= 40) begin
            if (mem_rd_en) begin
                rd_cnt++;
                rd_k = k;
                rd_a = int'(mem_rd_addr);
            end
            if (rsp_ready) begin
                got_lat  = k;
                got_data = int'(rsp_data);
            end
            req_valid = hold_busy && !hit && (k < LAT - 1);
            req_addr  = ~a;
            if (got_lat != 0) break;
            @(negedge clk);
            k++;
        end
        req_valid = 1'b0;
        check(got_lat == (hit ? 1 : LAT), lat_req, got_lat, hit ? 1 : LAT);
        check(got_data == int'(mem_byte(int'(a))), "R6", got_data, int'(mem_byte(int'(a))));
        if (hit) begin
            check(rd_cnt == 0, "R3", rd_cnt, 0);
        end else begin
            check(rd_cnt == 1 && rd_k == 1, "R4", rd_cnt * 16 + rd_k, 17);
            check(rd_a == int'(a[7:2]), "R4", rd_a, int'(a[7:2]));
        end
        @(negedge clk);
        check(!rsp_ready, "R5", int'(rsp_ready), 0);
        if (hold_busy)
            check(int'(access_count) == acc0 + 1, "R8", int'(access_count), acc0 + 1);
        exp_acc++;
        if (hit) exp_hit++;
        m_valid[idx] = 1'b1;
        m_tag[idx]   = a[7:4];
    endtask

    initial begin
        #(10ns * 150000);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_valid[i] = 1'b0;
            m_tag[i]   = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!rsp_ready, "R1", int'(rsp_ready), 0);
        check(!mem_rd_en, "R1", int'(mem_rd_en), 0);
        check(access_count == 0, "R1", int'(access_count), 0);
        check(hit_count == 0, "R1", int'(hit_count), 0);
        access(8'h00, 1'b0, "R1");

        // R2: upward sweep, fills each line then hits its other offsets
        for (int a = 1; a < 256; a++) access(8'(a), 1'b0, "R2");
        // R2: downward sweep
        for (int a = 255; a >= 0; a--) access(8'(a), 1'b0, "R2");

        // R7: eviction of one index leaves the others alone
        access(8'h04, 1'b0, "R7");
        access(8'h18, 1'b0, "R7");
        access(8'h34, 1'b0, "R7");
        access(8'h1B, 1'b0, "R7");
        access(8'h05, 1'b0, "R7");
        access(8'h36, 1'b0, "R7");

        // R8: strobe held high through a miss
        access(8'hC8, 1'b1, "R8");
        access(8'hE1, 1'b1, "R8");
        access(8'hC9, 1'b0, "R8");

        @(negedge clk);
        check(int'(access_count) == exp_acc, "R9", int'(access_count), exp_acc);
        check(int'(hit_count) == exp_hit, "R9", int'(hit_count), exp_hit);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule